// File: doc/BRIEF.md
# Serial Terminal Port Register Block

This block lets a 32-bit CPU talk to a character terminal through four word-wide registers on a simple memory bus. The CPU reads and writes status and data registers. Each direction has a one-character holding register. On the terminal side, each direction uses a valid/ready byte stream.

A character that arrives from the terminal is held until software reads it. While it is held, the port refuses further input. A write to the transmit data register places its low byte into an outgoing slot. That slot stays occupied until the terminal side takes the byte.

Each status register has two flags. Bit 0 is a read-only ready flag. Bit 1 is an interrupt enable that software can write. Each direction drives its own level-sensitive interrupt line.

The register window answers at a primary base address. Optionally, it also answers at a mirror base, so that code written for either address map runs unchanged.

Top module: `tport_regs`

## Requirements
- R1: At base 0xFFFFC000, the registers sit at these word offsets: receive status at 0x0, receive data at 0x4, transmit status at 0x8 and transmit data at 0xC. Address bits [1:0] are ignored. Reads are combinational in the cycle that `bus_req` is high with `bus_we` low.
- R2: The same four registers are also reached through mirror base 0xFFFF0000. A write through one base is visible through the other.
- R3: An access that falls in neither window, or at a window offset of 0x10 or above, reads zero. A write to such an address changes no register.
- R4: Receive status bit 0 reads 1 while an unread character is held. A read of the receive data register returns that character zero-extended to 32 bits.
- R5: A read of the receive data register clears the receive ready flag at the clock edge that ends the read. A status read in the next cycle returns bit 0 equal to 0.
- R6: `rx_in_ready` equals the inverse of the receive ready flag. A character offered while a character is held is not taken, and the held character stays unchanged.
- R7: `irq_hw[1]` is high exactly while receive status bit 1 (interrupt enable) and receive status bit 0 (ready) are both 1.
- R8: A write to transmit data puts bits [7:0] of the written word on `tx_out_data` and raises `tx_out_valid` after the clock edge. Transmit status bit 0 reads 0 from that edge until the edge where `tx_out_ready` is seen high.
- R9: While `tx_out_valid` is high and `tx_out_ready` is low, `tx_out_valid` stays high and `tx_out_data` does not change.
- R10: A write to transmit data while transmit status bit 0 is 0 is dropped. The pending byte is kept.
- R11: `irq_hw[0]` is high exactly while transmit status bit 1 (interrupt enable) and transmit status bit 0 (ready) are both 1.
- R12: A write to either status register changes only bit 1. Bit 0 ignores the write, and bits [31:2] read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 32 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| rx_in_valid | input | 1 | Terminal offers a character |
| rx_in_data | input | 8 | Offered character |
| rx_in_ready | output | 1 | Port can take a character |
| tx_out_valid | output | 1 | A byte is waiting for the terminal |
| tx_out_data | output | 8 | Outgoing byte |
| tx_out_ready | input | 1 | Terminal takes the byte |
| irq_hw | output | 2 | Bit 0: transmit interrupt, bit 1: receive interrupt |

## Verification
A table of register accesses covers several address patterns:
- each offset at the primary base;
- the same offsets at the mirror base;
- an unmapped offset inside the window;
- an address outside both windows;
- status writes with every bit set and with only bit 0 set.

Together these separate a correct decode from one that ignores the mirror, aliases unmapped offsets or writes the read-only flag.

Directed sequences then cover the terminal side:
- a character offered while another is held, to show that back-pressure works and the held character is kept;
- a read followed at once by a status read, to place the clearing edge;
- a stalled transmit byte with a second write issued during the stall, to show that the slot holds its byte and drops the extra one.

Interrupt lines are sampled after each enable change and after each data movement.

// File: rtl/tport_pkg.sv
package tport_pkg;

   // register selected by the current bus address
   typedef enum logic [2:0] {
      SEL_NONE    = 3'd0,
      SEL_RX_STAT = 3'd1,
      SEL_RX_DATA = 3'd2,
      SEL_TX_STAT = 3'd3,
      SEL_TX_DATA = 3'd4
   } tport_sel_e;

   // word index of each register inside the window
   localparam int unsigned WORD_RX_STAT = 0;
   localparam int unsigned WORD_RX_DATA = 1;
   localparam int unsigned WORD_TX_STAT = 2;
   localparam int unsigned WORD_TX_DATA = 3;

   // status flag positions (software depends on these)
   localparam int unsigned FLAG_READY = 0;
   localparam int unsigned FLAG_IE    = 1;

endpackage

// File: rtl/tport_decode.sv
module tport_decode
   import tport_pkg::*;
#(
   parameter int unsigned          ADDR_W      = 32,
   parameter int unsigned          WIN_AW      = 8,
   parameter logic [ADDR_W-1:0]    BASE        = 32'hFFFF_C000,
   parameter logic [ADDR_W-1:0]    MIRROR_BASE = 32'hFFFF_0000,
   parameter bit                   MIRROR_EN   = 1'b1
)(
   input  logic [ADDR_W-1:0] addr,
   output tport_sel_e        sel
);

   localparam int unsigned WW = WIN_AW - 2;

   generate
      if (WIN_AW < 4 || WIN_AW >= ADDR_W) begin : g_bad_win
         $error("tport_decode: WIN_AW must lie in [4, ADDR_W-1]");
      end
      if (BASE[WIN_AW-1:0] != '0) begin : g_bad_base
         $error("tport_decode: BASE must be aligned to the window size");
      end
      if (MIRROR_EN && MIRROR_BASE[WIN_AW-1:0] != '0) begin : g_bad_mirror
         $error("tport_decode: MIRROR_BASE must be aligned to the window size");
      end
   endgenerate

   logic          hit_pri;
   logic          hit_mir;
   logic [WW-1:0] word;
   logic          unused_low;

   assign hit_pri    = (addr[ADDR_W-1:WIN_AW] == BASE[ADDR_W-1:WIN_AW]);
   assign word       = addr[WIN_AW-1:2];
   assign unused_low = ^addr[1:0];

   generate
      if (MIRROR_EN) begin : g_mirror
         assign hit_mir = (addr[ADDR_W-1:WIN_AW] == MIRROR_BASE[ADDR_W-1:WIN_AW]);
      end else begin : g_no_mirror
         assign hit_mir = 1'b0;
      end
   endgenerate

   always_comb begin
      sel = SEL_NONE;
      if (hit_pri || hit_mir) begin
         if      (word == WW'(WORD_RX_STAT)) sel = SEL_RX_STAT;
         else if (word == WW'(WORD_RX_DATA)) sel = SEL_RX_DATA;
         else if (word == WW'(WORD_TX_STAT)) sel = SEL_TX_STAT;
         else if (word == WW'(WORD_TX_DATA)) sel = SEL_TX_DATA;
      end
   end

endmodule

// File: rtl/tport_rx_hold.sv
module tport_rx_hold #(
   parameter int unsigned CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [CHAR_W-1:0] in_data,
   output logic              in_ready,
   input  logic              pop,
   input  logic              ie_wr,
   input  logic              ie_wdata,
   output logic              full,
   output logic              ie,
   output logic [CHAR_W-1:0] char_q
);

   generate
      if (CHAR_W < 1) begin : g_bad_char
         $error("tport_rx_hold: CHAR_W must be at least 1");
      end
   endgenerate

   logic accept;

   assign in_ready = ~full;
   assign accept   = in_valid & ~full;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         full   <= 1'b0;
         char_q <= '0;
      end else if (accept) begin
         full   <= 1'b1;
         char_q <= in_data;
      end else if (pop) begin
         full   <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ie <= 1'b0;
      else if (ie_wr) ie <= ie_wdata;
   end

   AST_RX_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      full && !pop |=> full && $stable(char_q)); // R6

   AST_RX_POP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      full && pop |=> !full); // R5

endmodule

// File: rtl/tport_tx_hold.sv
module tport_tx_hold #(
   parameter int unsigned CHAR_W = 8
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [CHAR_W-1:0] push_data,
   output logic              out_valid,
   output logic [CHAR_W-1:0] out_data,
   input  logic              out_ready,
   input  logic              ie_wr,
   input  logic              ie_wdata,
   output logic              can_accept,
   output logic              ie
);

   logic pending;
   logic load;

   assign can_accept = ~pending;
   assign load       = push & ~pending;
   assign out_valid  = pending;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pending  <= 1'b0;
         out_data <= '0;
      end else if (load) begin
         pending  <= 1'b1;
         out_data <= push_data;
      end else if (pending && out_ready) begin
         pending  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)     ie <= 1'b0;
      else if (ie_wr) ie <= ie_wdata;
   end

   AST_TX_BUSY_AFTER_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
      push && can_accept |=> !can_accept); // R8

   AST_TX_HOLD_WHILE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_data)); // R9

endmodule

// File: rtl/tport_regs.sv
module tport_regs
   import tport_pkg::*;
#(
   parameter int unsigned       ADDR_W      = 32,
   parameter int unsigned       DATA_W      = 32,
   parameter int unsigned       CHAR_W      = 8,
   parameter int unsigned       WIN_AW      = 8,
   parameter logic [ADDR_W-1:0] BASE        = 32'hFFFF_C000,
   parameter logic [ADDR_W-1:0] MIRROR_BASE = 32'hFFFF_0000,
   parameter bit                MIRROR_EN   = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_req,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              rx_in_valid,
   input  logic [CHAR_W-1:0] rx_in_data,
   output logic              rx_in_ready,
   output logic              tx_out_valid,
   output logic [CHAR_W-1:0] tx_out_data,
   input  logic              tx_out_ready,
   output logic [1:0]        irq_hw
);

   localparam int unsigned IRQ_TX = 0;
   localparam int unsigned IRQ_RX = 1;

   generate
      if (DATA_W < CHAR_W || DATA_W < 2) begin : g_bad_data
         $error("tport_regs: DATA_W must hold a character and two flags");
      end
   endgenerate

   tport_sel_e  sel;
   logic        rd;
   logic        wr;
   logic        rx_full;
   logic        rx_ie;
   logic        tx_can;
   logic        tx_ie;
   logic [CHAR_W-1:0] rx_char;
   logic        unused_wdata;

   assign rd           = bus_req & ~bus_we;
   assign wr           = bus_req &  bus_we;
   assign unused_wdata = ^bus_wdata;

   tport_decode #(
      .ADDR_W      (ADDR_W),
      .WIN_AW      (WIN_AW),
      .BASE        (BASE),
      .MIRROR_BASE (MIRROR_BASE),
      .MIRROR_EN   (MIRROR_EN)
   ) u_decode (
      .addr (bus_addr),
      .sel  (sel)
   );

   tport_rx_hold #(.CHAR_W(CHAR_W)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_valid (rx_in_valid),
      .in_data  (rx_in_data),
      .in_ready (rx_in_ready),
      .pop      (rd && sel == SEL_RX_DATA),
      .ie_wr    (wr && sel == SEL_RX_STAT),
      .ie_wdata (bus_wdata[FLAG_IE]),
      .full     (rx_full),
      .ie       (rx_ie),
      .char_q   (rx_char)
   );

   tport_tx_hold #(.CHAR_W(CHAR_W)) u_tx (
      .clk        (clk),
      .rst_n      (rst_n),
      .push       (wr && sel == SEL_TX_DATA),
      .push_data  (bus_wdata[CHAR_W-1:0]),
      .out_valid  (tx_out_valid),
      .out_data   (tx_out_data),
      .out_ready  (tx_out_ready),
      .ie_wr      (wr && sel == SEL_TX_STAT),
      .ie_wdata   (bus_wdata[FLAG_IE]),
      .can_accept (tx_can),
      .ie         (tx_ie)
   );

   function automatic logic [DATA_W-1:0] stat_word(input logic ie_b, input logic rdy_b);
      logic [DATA_W-1:0] w;
      w = '0;
      w[FLAG_IE]    = ie_b;
      w[FLAG_READY] = rdy_b;
      return w;
   endfunction

   always_comb begin
      bus_rdata = '0;
      if (rd) begin
         unique case (sel)
            SEL_RX_STAT: bus_rdata = stat_word(rx_ie, rx_full);
            SEL_RX_DATA: bus_rdata = DATA_W'(rx_char);
            SEL_TX_STAT: bus_rdata = stat_word(tx_ie, tx_can);
            SEL_TX_DATA: bus_rdata = '0;
            default:     bus_rdata = '0;
         endcase
      end
   end

   assign irq_hw[IRQ_TX] = tx_ie & tx_can;
   assign irq_hw[IRQ_RX] = rx_ie & rx_full;

   AST_UNMAPPED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      wr && sel == SEL_NONE |=> $stable(rx_ie) && $stable(tx_ie)); // R3

endmodule

// File: tb/tb_tport_regs.sv
module tb_tport_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_req = 1'b0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        rx_in_valid = 1'b0;
   logic [7:0]  rx_in_data = '0;
   logic        rx_in_ready;
   logic        tx_out_valid;
   logic [7:0]  tx_out_data;
   logic        tx_out_ready = 1'b0;
   logic [1:0]  irq_hw;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   tport_regs dut (
      .clk(clk), .rst_n(rst_n),
      .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_ready(rx_in_ready),
      .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data), .tx_out_ready(tx_out_ready),
      .irq_hw(irq_hw)
   );

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [31:0] data;
      logic [7:0]  req;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [0:NV-1] = '{
      '{1'b0, 32'hFFFF_C000, 32'h0000_0000, 8'd1},  // R1 rx status empty
      '{1'b0, 32'hFFFF_C008, 32'h0000_0001, 8'd1},  // R1 tx status ready
      '{1'b0, 32'hFFFF_C004, 32'h0000_0000, 8'd1},  // R1 rx data after reset
      '{1'b1, 32'hFFFF_C000, 32'hFFFF_FFFF, 8'd12}, // R12 all ones to rx status
      '{1'b0, 32'hFFFF_C000, 32'h0000_0002, 8'd12}, // R12 only enable took
      '{1'b0, 32'hFFFF_0000, 32'h0000_0002, 8'd2},  // R2 mirror sees it
      '{1'b1, 32'hFFFF_0008, 32'h0000_0002, 8'd2},  // R2 write via mirror
      '{1'b0, 32'hFFFF_C008, 32'h0000_0003, 8'd2},  // R2 primary sees it
      '{1'b0, 32'hFFFF_C010, 32'h0000_0000, 8'd3},  // R3 unmapped offset
      '{1'b1, 32'hFFFF_C010, 32'h0000_0000, 8'd3},  // R3 unmapped write
      '{1'b0, 32'hFFFF_C000, 32'h0000_0002, 8'd3},  // R3 enable untouched
      '{1'b0, 32'h1234_5600, 32'h0000_0000, 8'd3},  // R3 outside windows
      '{1'b1, 32'hFFFF_C000, 32'h0000_0001, 8'd12}, // R12 bit0 only
      '{1'b0, 32'hFFFF_C000, 32'h0000_0000, 8'd12}, // R12 enable cleared
      '{1'b1, 32'hFFFF_0008, 32'h0000_0000, 8'd2},  // R2 clear tx enable
      '{1'b0, 32'hFFFF_0008, 32'h0000_0001, 8'd2}   // R2 via mirror
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_rd(input logic [31:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(posedge clk); #1;
      bus_req = 1'b0;
   endtask

   task automatic bus_wr(input logic [31:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_req = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk); #1;
      bus_req = 1'b0; bus_we = 1'b0;
   endtask

   task automatic offer(input logic [7:0] c, output logic rdy);
      @(negedge clk);
      rx_in_valid = 1'b1; rx_in_data = c;
      #1 rdy = rx_in_ready;
      @(posedge clk); #1;
      rx_in_valid = 1'b0;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] d;
      logic        r;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // reset state
      check("reset irq", {30'd0, irq_hw}, 32'd0);
      check("reset R6 rx_in_ready", {31'd0, rx_in_ready}, 32'd1);
      check("reset R8 tx_out_valid", {31'd0, tx_out_valid}, 32'd0);

      for (int i = 0; i < NV; i++) begin
         if (VEC[i].wr) bus_wr(VEC[i].addr, VEC[i].data);
         else begin
            bus_rd(VEC[i].addr, d);
            check($sformatf("R%0d vector %0d", VEC[i].req, i), d, VEC[i].data);
         end
      end

      // receive path: R4 R5 R6
      offer(8'h5A, r);
      check("R6 ready when empty", {31'd0, r}, 32'd1);
      bus_rd(32'hFFFF_C000, d);
      check("R4 status after char", d, 32'd1);
      offer(8'hA3, r);
      check("R6 ready low when full", {31'd0, r}, 32'd0);
      bus_rd(32'hFFFF_C004, d);
      check("R4 R6 held char kept", d, 32'h0000_005A);
      bus_rd(32'hFFFF_C000, d);
      check("R5 ready cleared", d, 32'd0);
      offer(8'hA3, r);
      check("R6 accept after read", {31'd0, r}, 32'd1);

      // receive interrupt: R7
      check("R7 irq off with ie=0", {31'd0, irq_hw[1]}, 32'd0);
      bus_wr(32'hFFFF_C000, 32'h2);
      check("R7 irq on", {31'd0, irq_hw[1]}, 32'd1);
      bus_rd(32'hFFFF_0004, d);
      check("R2 R4 mirror data read", d, 32'h0000_00A3);
      check("R7 irq off after read", {31'd0, irq_hw[1]}, 32'd0);
      bus_wr(32'hFFFF_C000, 32'h0);

      // transmit path: R8 R9 R10 R11
      bus_wr(32'hFFFF_C008, 32'h2);
      check("R11 irq on when ready", {31'd0, irq_hw[0]}, 32'd1);
      bus_wr(32'hFFFF_C00C, 32'h1234_5678);
      check("R8 valid after write", {31'd0, tx_out_valid}, 32'd1);
      check("R8 low byte", {24'd0, tx_out_data}, 32'h78);
      check("R11 irq off while busy", {31'd0, irq_hw[0]}, 32'd0);
      bus_rd(32'hFFFF_C008, d);
      check("R8 status busy", d, 32'h2);
      repeat (3) @(posedge clk);
      #1 check("R9 held valid", {31'd0, tx_out_valid}, 32'd1);
      check("R9 held data", {24'd0, tx_out_data}, 32'h78);
      bus_wr(32'hFFFF_C00C, 32'h99);
      check("R10 busy write dropped", {24'd0, tx_out_data}, 32'h78);
      @(negedge clk); tx_out_ready = 1'b1;
      @(posedge clk); #1;
      check("R8 valid cleared", {31'd0, tx_out_valid}, 32'd0);
      check("R11 irq back on", {31'd0, irq_hw[0]}, 32'd1);
      bus_rd(32'hFFFF_C008, d);
      check("R8 ready again", d, 32'h3);
      check("R10 no late send", {31'd0, tx_out_valid}, 32'd0);
      @(negedge clk); tx_out_ready = 1'b0;
      bus_wr(32'hFFFF_000C, 32'hABCD_EF3C);
      check("R2 R8 mirror tx byte", {24'd0, tx_out_data}, 32'h3C);
      @(negedge clk); tx_out_ready = 1'b1;
      @(posedge clk); #1;
      check("R8 mirror byte taken", {31'd0, tx_out_valid}, 32'd0);

      finish_run();
   end

endmodule